// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Register Front End

This block is the digital side of a two-channel digital-to-analog converter. A single 12-bit parallel bus carries a full code word in one write. Each channel holds two registers in series. A staging register is filled by the write strobe when the select line points at that channel. A held register behind it supplies the code that drives the converter core. One load strobe moves both staging registers into both held registers at the same moment, so the two outputs can change together.

The strobes and the select line arrive without any relation to the system clock. The block passes them, together with the bus, through a two-stage synchroniser, so that data and controls stay aligned with each other. Each register then acts as a level-sensitive pass-through: while its strobe is low it takes a new value on every clock edge, and when the strobe returns high it keeps the last value taken. With both strobes low, bus data runs straight to the selected output. A monitor raises a one-cycle flag when the bus or the select line changed shortly before a write strobe was released.

Top module: `dac_dbuf_if`

## Requirements
- R1: While `rst_ni` is low, both output codes are 0 and `setup_err_o` is 0. Code 0 is the lowest output code.
- R2: A write with `wr_ni` low loads the full 12-bit bus word into one channel in a single operation. `sel_i` = 0 selects channel A and `sel_i` = 1 selects channel B. While `ld_ni` is high, a write changes neither output code.
- R3: During a write, the staging register of the channel that is not selected keeps its value.
- R4: While `ld_ni` is low, each output code follows its own staging register. When `ld_ni` rises, the output keeps the value it held at that moment.
- R5: With both strobes low, the output code of the selected channel follows the bus. The output of the other channel follows its own staging register, which holds its value.
- R6: While both strobes are high, neither output code changes, whatever the bus and `sel_i` do.
- R7: Two-step update: one channel is written with `ld_ni` high. The other channel is then written with `ld_ni` low, and both outputs show the new pair.
- R8: Three-step update: both channels are written with `ld_ni` high and the outputs stay unchanged. A later low pulse on `ld_ni` then moves both words to the outputs.
- R9: When `sel_i` and `ld_ni` are driven by one shared signal, writing B first and A second delivers both new words. Writing A first leaves the old staging value of B on output B.
- R10: A change on the bus or on a strobe reaches an output code on the third rising clock edge after the change: two synchroniser stages plus one register stage.
- R11: `setup_err_o` pulses high for exactly one cycle when a synchronised write strobe rises fewer than `SETUP_CYC` cycles after the last change of the bus or `sel_i`. It stays low when both have been stable for at least `SETUP_CYC` cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_i | input | 12 | Shared parallel code bus |
| sel_i | input | 1 | Channel select: 0 for A, 1 for B |
| wr_ni | input | 1 | Active-low write strobe, asynchronous |
| ld_ni | input | 1 | Active-low load strobe, asynchronous, acts on both channels |
| code_a_o | output | 12 | Held output code of channel A |
| code_b_o | output | 12 | Held output code of channel B |
| setup_err_o | output | 1 | One-cycle flag for a bus or select change too close to a write release |

## Verification
The hardest situation to reach is the shared select-and-load wiring. There, writing channel A opens the load path at the same moment, and output B silently takes whatever staging value B had. The bench drives `sel_i` and `ld_ni` from one variable and runs both write orders back to back, so a stale B value becomes visible on the port. The setup-window flag is reached by changing the bus two cycles before the write strobe is released, inside an otherwise clean write sequence. The bench also counts the flag pulses over the whole run, so a clean write must leave the count unchanged.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;
  localparam int unsigned NUM_CH = 2;
  typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} ch_sel_e;
endpackage

// File: rtl/dac_sync.sv
module dac_sync #(
  parameter int unsigned W      = 15,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] pipe_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) pipe_q[i] <= RST_VAL;
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/dac_chan.sv
module dac_chan
  import dac_dbuf_pkg::*;
#(
  parameter int unsigned DW    = 12,
  parameter ch_sel_e     CH_ID = CH_A
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          sel_i,
  input  logic          wr_ni,
  input  logic          ld_ni,
  output logic [DW-1:0] code_o
);
  logic          wr_hit;
  logic [DW-1:0] stage_q, held_q;

  assign wr_hit = !wr_ni && (ch_sel_e'(sel_i) == CH_ID);

  // level-sensitive pair modelled as per-edge updates while a strobe is low
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
      held_q  <= '0;
    end else begin
      if (wr_hit) stage_q <= data_i;
      if (!ld_ni) held_q  <= wr_hit ? data_i : stage_q;
    end
  end

  assign code_o = held_q;

  p_stage_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> $stable(stage_q));
  p_held_latched_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ni |=> $stable(code_o));
  p_follow_stage_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ni && !wr_hit) |=> (code_o == $past(stage_q)));
  p_pass_through_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ld_ni && wr_hit) |=> (code_o == $past(data_i)));
endmodule

// File: rtl/dac_setup_mon.sv
module dac_setup_mon #(
  parameter int unsigned DW        = 12,
  parameter int unsigned SETUP_CYC = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          sel_i,
  input  logic          wr_ni,
  output logic          err_o
);
  localparam int unsigned CW = $clog2(SETUP_CYC + 1);

  logic [DW:0]   watch_q;
  logic [CW-1:0] stable_q;
  logic          wr_q, err_q, changed, wr_rise;

  assign changed = ({sel_i, data_i} != watch_q);
  assign wr_rise = !wr_q && wr_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      watch_q  <= '0;
      stable_q <= '0;
      wr_q     <= 1'b1;
      err_q    <= 1'b0;
    end else begin
      watch_q <= {sel_i, data_i};
      wr_q    <= wr_ni;
      if (changed)                         stable_q <= '0;
      else if (stable_q != CW'(SETUP_CYC)) stable_q <= stable_q + 1'b1;
      err_q <= wr_rise && (changed || stable_q < CW'(SETUP_CYC));
    end
  end

  assign err_o = err_q;

  p_single_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> !err_o);
  p_flag_after_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> wr_q);
endmodule

// File: rtl/dac_dbuf_if.sv
module dac_dbuf_if
  import dac_dbuf_pkg::*;
#(
  parameter int unsigned DW          = 12,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETUP_CYC   = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] data_i,
  input  logic          sel_i,
  input  logic          wr_ni,
  input  logic          ld_ni,
  output logic [DW-1:0] code_a_o,
  output logic [DW-1:0] code_b_o,
  output logic          setup_err_o
);
  localparam int unsigned SW = DW + 3;
  localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, {DW{1'b0}}};

  logic [SW-1:0] raw, synced;
  logic [DW-1:0] data_s;
  logic          sel_s, wr_s, ld_s;
  logic [DW-1:0] code [NUM_CH];

  assign raw = {sel_i, wr_ni, ld_ni, data_i};
  assign {sel_s, wr_s, ld_s, data_s} = synced;

  dac_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk_i, .rst_ni, .d_i(raw), .q_o(synced)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    dac_chan #(.DW(DW), .CH_ID(g == 0 ? CH_A : CH_B)) u_chan (
      .clk_i, .rst_ni, .data_i(data_s), .sel_i(sel_s),
      .wr_ni(wr_s), .ld_ni(ld_s), .code_o(code[g])
    );
  end

  dac_setup_mon #(.DW(DW), .SETUP_CYC(SETUP_CYC)) u_mon (
    .clk_i, .rst_ni, .data_i(data_s), .sel_i(sel_s), .wr_ni(wr_s),
    .err_o(setup_err_o)
  );

  assign code_a_o = code[0];
  assign code_b_o = code[1];

  p_reset_clear_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (code_a_o == '0 && code_b_o == '0 && !setup_err_o));
endmodule

// File: tb/sim_dac_dbuf_if.sv
`timescale 1ns/1ps
module sim_dac_dbuf_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] d_r = '0;
  logic        s_r = 1'b0, w_r = 1'b1, l_r = 1'b1;
  logic [11:0] code_a, code_b;
  logic        serr;
  int checks = 0, errors = 0, flag_cnt = 0;

  always #2.5 clk = ~clk;

  dac_dbuf_if u0 (
    .clk_i(clk), .rst_ni(rst_n), .data_i(d_r), .sel_i(s_r),
    .wr_ni(w_r), .ld_ni(l_r), .code_a_o(code_a), .code_b_o(code_b),
    .setup_err_o(serr)
  );

  always @(negedge clk) if (rst_n && serr) flag_cnt++;

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [11:0] d, logic s, logic w, logic l);
    d_r = d; s_r = s; w_r = w; l_r = l;
  endtask

  task automatic wr_word(logic s, logic [11:0] d, logic l);
    drive(d, s, 1'b0, l); step(8);
    drive(d, s, 1'b1, l); step(8);
  endtask

  task automatic pulse_ld();
    l_r = 1'b0; step(8);
    l_r = 1'b1; step(8);
  endtask

  task automatic t_reset();
    step(1);
    chk("R1 code_a", code_a, 0);
    chk("R1 code_b", code_b, 0);
    chk("R1 flag", serr, 0);
    rst_n = 1'b1; step(6);
  endtask

  task automatic t_buffered();
    wr_word(1'b0, 12'hABC, 1'b1);
    chk("R2 A write no output change", code_a, 0);
    wr_word(1'b1, 12'h123, 1'b1);
    chk("R2 B write no output change", code_b, 0);
    pulse_ld();
    chk("R3 A staging kept across B write", code_a, 12'hABC);
    chk("R4 B moved on load", code_b, 12'h123);
  endtask

  task automatic t_hold();
    drive(12'h5A5, 1'b1, 1'b1, 1'b1); step(4);
    drive(12'hFFF, 1'b0, 1'b1, 1'b1); step(6);
    chk("R6 A unchanged", code_a, 12'hABC);
    chk("R6 B unchanged", code_b, 12'h123);
  endtask

  task automatic t_pass();
    drive(12'h111, 1'b0, 1'b0, 1'b0); step(8);
    chk("R5 A follows bus", code_a, 12'h111);
    chk("R5 B follows staging", code_b, 12'h123);
    drive(12'h2A5, 1'b0, 1'b0, 1'b0);
    step(2);
    chk("R10 not yet after two edges", code_a, 12'h111);
    step(1);
    chk("R10 updated on third edge", code_a, 12'h2A5);
    step(8);
    w_r = 1'b1; step(6);
    l_r = 1'b1; step(6);
    drive(12'h000, 1'b1, 1'b1, 1'b1); step(6);
    chk("R4 captured at load rise", code_a, 12'h2A5);
  endtask

  task automatic t_two_step();
    wr_word(1'b0, 12'h0F0, 1'b1);
    chk("R7 first write held back", code_a, 12'h2A5);
    drive(12'hF0F, 1'b1, 1'b0, 1'b0); step(8);
    chk("R7 A shown", code_a, 12'h0F0);
    chk("R7 B shown", code_b, 12'hF0F);
    drive(12'hF0F, 1'b1, 1'b1, 1'b0); step(6);
    l_r = 1'b1; step(6);
  endtask

  task automatic t_three_step();
    wr_word(1'b0, 12'h7FF, 1'b1);
    wr_word(1'b1, 12'h800, 1'b1);
    chk("R8 A waits for load", code_a, 12'h0F0);
    chk("R8 B waits for load", code_b, 12'hF0F);
    pulse_ld();
    chk("R8 A after load", code_a, 12'h7FF);
    chk("R8 B after load", code_b, 12'h800);
  endtask

  task automatic t_shared();
    wr_word(1'b1, 12'h321, 1'b1);
    wr_word(1'b0, 12'h654, 1'b0);
    chk("R9 B-first A", code_a, 12'h654);
    chk("R9 B-first B", code_b, 12'h321);
    wr_word(1'b0, 12'hAAA, 1'b0);
    wr_word(1'b1, 12'hBBB, 1'b1);
    chk("R9 A-first A", code_a, 12'hAAA);
    chk("R9 A-first B stale", code_b, 12'h321);
  endtask

  task automatic t_setup();
    chk("R11 no flag on clean writes", flag_cnt, 0);
    drive(12'h010, 1'b0, 1'b0, 1'b1); step(8);
    d_r = 12'h020; step(2);
    w_r = 1'b1; step(8);
    chk("R11 flag on late change", flag_cnt, 1);
    wr_word(1'b0, 12'h030, 1'b1);
    chk("R11 no flag on stable write", flag_cnt, 1);
  endtask

  initial begin
    t_reset();
    t_buffered();
    t_hold();
    t_pass();
    t_two_step();
    t_three_step();
    t_shared();
    t_setup();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule